// File: doc/BRIEF.md
# GPIO Direct Interrupt Router

This block takes the input pads of one GPIO bank and steers selected pads onto sixteen dedicated, active-high interrupt lines. Each pad owns a 32-bit configuration word. Four bits of that word matter here: one bit lets the pad drive a direct interrupt, two bits enable detection of the rising edge and of the falling edge, and one bit chooses level mode instead of edge mode. A separate table of four 32-bit slot registers names, for each of the sixteen interrupt lines, the pad that drives it. Each line is identified by a pad index of eight bits.

The pad inputs pass through a two-flop synchronizer. An edge is found by comparing the newest synchronized sample with the one before it. In edge mode, an enabled edge produces a single-cycle pulse on every line mapped to that pad. In level mode, the line follows the synchronized pad value. The interrupt outputs are registered.

Software programs the block through a plain register port. Writes take effect on the clock edge. Reads are combinational and return the stored word.

Top module: `gpio_dirq_router`

## Requirements
- R1: After reset, all interrupt outputs are low, and every slot register and every pad configuration word reads zero.
- R2: Slot register j (j = 0..3) sits at byte offset 0x980 + 4*j. Its byte lane k (bits 8k+7:8k) holds the pad index for interrupt line 4*j + k.
- R3: The configuration word of pad p sits at byte offset 4*p, for p below NUM_PADS. A read returns the last word written there.
- R4: When bit 27 of the mapped pad's configuration word is clear, the line stays low whatever the pad does and whatever the other configuration bits are.
- R5: With bit 24 = 0 and bit 25 = 1, a rising pad edge makes the line high for exactly one cycle. The line is high during the third clock cycle after the pad changes, counting the first clock edge that samples the new value as edge 0. A falling edge gives no pulse in this setting.
- R6: With bit 24 = 0 and bit 26 = 1, a falling pad edge gives the same single-cycle pulse, with the same timing, and a rising edge gives none.
- R7: With bit 24 = 0 and bits 25 and 26 both set, each edge in either direction gives one pulse.
- R8: With bit 24 = 1, the line follows the pad level, delayed by the same three-stage latency, and it ignores bits 25 and 26.
- R9: A slot whose pad index is NUM_PADS or greater drives its line low. The index is never truncated onto an implemented pad.
- R10: Writes to any offset outside the two windows change nothing. This includes misaligned offsets. Reads from such offsets return zero.
- R11: One pad may be mapped to several slots, and every one of those lines then fires together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pad_in | input | NUM_PADS | Raw pad input levels |
| irq_o | output | 16 | Dedicated interrupt lines, active high |

## Verification
Rising-only, falling-only and both-edge pads are each driven through a full high-then-low cycle. This separates the polarity enables from each other and shows that a non-enabled edge stays silent. A level-mode pad that also has an edge bit set shows that the mode bit overrides the edge bits and that the line holds for as long as the pad does. A slot whose index has the same low bits as an active pad, but lies beyond the pad count, exposes truncating index logic. Mapping several slots to one pad, and reaching a line in the middle of the second slot register, pins down the byte-lane order.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int NUM_SLOTS  = 16;
  localparam int SLOT_REGS  = NUM_SLOTS / 4;
  localparam int IDX_W      = 8;
  localparam int SLOT_BASE  = 'h980;
  localparam int CFG_EN     = 27;
  localparam int CFG_FALL   = 26;
  localparam int CFG_RISE   = 25;
  localparam int CFG_LEVEL  = 24;

  typedef struct packed {
    logic en;
    logic fall;
    logic rise;
    logic level;
  } trig_t;
endpackage

// File: rtl/dirq_regs.sv
module dirq_regs
  import dirq_pkg::*;
#(
  parameter int NUM_PADS = 32,
  parameter int ADDR_W   = 12
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [31:0]                        wr_data,
  input  logic [ADDR_W-1:0]                  rd_addr,
  output logic [31:0]                        rd_data,
  output trig_t [NUM_PADS-1:0]               trig,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0]    slot_idx
);
  localparam int CFG_END = 4 * NUM_PADS;

  logic [NUM_PADS-1:0][31:0]  cfg_q;
  logic [SLOT_REGS-1:0][31:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      slot_q <= '0;
    end else if (wr_en && wr_addr[1:0] == 2'b00) begin
      for (int p = 0; p < NUM_PADS; p++)
        if (int'(wr_addr) == 4 * p) cfg_q[p] <= wr_data;
      for (int j = 0; j < SLOT_REGS; j++)
        if (int'(wr_addr) == SLOT_BASE + 4 * j) slot_q[j] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[1:0] == 2'b00) begin
      for (int p = 0; p < NUM_PADS; p++)
        if (int'(rd_addr) == 4 * p) rd_data = cfg_q[p];
      for (int j = 0; j < SLOT_REGS; j++)
        if (int'(rd_addr) == SLOT_BASE + 4 * j) rd_data = slot_q[j];
    end
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_trig
    assign trig[p] = '{en:    cfg_q[p][CFG_EN],
                       fall:  cfg_q[p][CFG_FALL],
                       rise:  cfg_q[p][CFG_RISE],
                       level: cfg_q[p][CFG_LEVEL]};
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_idx[s] = slot_q[s / 4][8 * (s % 4) +: IDX_W];
  end

  logic wr_in_window;
  always_comb begin
    wr_in_window = 1'b0;
    if (wr_addr[1:0] == 2'b00) begin
      if (int'(wr_addr) < CFG_END) wr_in_window = 1'b1;
      if (int'(wr_addr) >= SLOT_BASE && int'(wr_addr) < SLOT_BASE + 4 * SLOT_REGS)
        wr_in_window = 1'b1;
    end
  end

  p_slot_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == SLOT_BASE + 4) |=> slot_idx[5] == $past(wr_data[15:8]));

  p_oob_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_in_window) |=> ($stable(slot_idx) && $stable(trig)));
endmodule

// File: rtl/dirq_sync.sv
module dirq_sync #(
  parameter int NUM_PADS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] lvl,
  output logic [NUM_PADS-1:0] rose,
  output logic [NUM_PADS-1:0] fell
);
  logic [NUM_PADS-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rose = sync_q & ~prev_q;
  assign fell = ~sync_q & prev_q;

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  p_sync_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> sync_q == $past(pad_in, 2));
endmodule

// File: rtl/dirq_slot.sv
module dirq_slot
  import dirq_pkg::*;
#(
  parameter int NUM_PADS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     idx,
  input  trig_t [NUM_PADS-1:0] trig,
  input  logic [NUM_PADS-1:0]  lvl,
  input  logic [NUM_PADS-1:0]  rose,
  input  logic [NUM_PADS-1:0]  fell,
  output logic                 irq
);
  localparam int PAD_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

  logic             idx_ok;
  logic [PAD_W-1:0] sel;
  trig_t            t;
  logic             l, r, f, hit;

  assign idx_ok = int'(idx) < NUM_PADS;
  assign sel    = idx[PAD_W-1:0];

  always_comb begin
    t = '0; l = 1'b0; r = 1'b0; f = 1'b0;
    if (idx_ok) begin
      t = trig[sel];
      l = lvl[sel];
      r = rose[sel];
      f = fell[sel];
    end
    hit = t.level ? l : ((t.rise & r) | (t.fall & f));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= idx_ok & t.en & hit;
  end

  p_unmapped_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_ok |=> !irq);

  p_disabled_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_ok && !trig[sel].en) |=> !irq);
endmodule

// File: rtl/gpio_dirq_router.sv
module gpio_dirq_router
  import dirq_pkg::*;
#(
  parameter int NUM_PADS = 32,
  parameter int ADDR_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [31:0]          rd_data,
  input  logic [NUM_PADS-1:0]  pad_in,
  output logic [15:0]          irq_o
);
  trig_t [NUM_PADS-1:0]            trig;
  logic [NUM_SLOTS-1:0][IDX_W-1:0] slot_idx;
  logic [NUM_PADS-1:0]             lvl, rose, fell;

  dirq_regs #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .trig(trig), .slot_idx(slot_idx));

  dirq_sync #(.NUM_PADS(NUM_PADS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .lvl(lvl), .rose(rose), .fell(fell));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_line
    dirq_slot #(.NUM_PADS(NUM_PADS)) u_slot (
      .clk(clk), .rst_n(rst_n), .idx(slot_idx[s]), .trig(trig),
      .lvl(lvl), .rose(rose), .fell(fell), .irq(irq_o[s]));
  end

  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |=> irq_o == '0);
endmodule

// File: tb/gpio_dirq_router_tb.sv
module gpio_dirq_router_tb_top;
  localparam int NP = 32;
  localparam logic [31:0] EN = 32'h0800_0000, FALL = 32'h0400_0000,
                          RISE = 32'h0200_0000, LVL = 32'h0100_0000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NP-1:0] pad_in = '0;
  logic [15:0] irq_o;
  int checks = 0, errors = 0;
  logic [7:0] smap [16];

  always #2.5 clk = ~clk;

  gpio_dirq_router #(.NUM_PADS(NP), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pad_in(pad_in), .irq_o(irq_o));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); rd_addr = a; #1;
    check(rd_data, exp, req);
  endtask

  task automatic push_map();
    for (int j = 0; j < 4; j++)
      wr(12'h980 + 12'(4 * j), {smap[4*j+3], smap[4*j+2], smap[4*j+1], smap[4*j]});
    repeat (2) @(negedge clk);
  endtask

  // drive a pad at a falling edge; check irq after edges 1, 2 and 3
  task automatic step(input int p, input logic v, input logic [15:0] e1,
                      input logic [15:0] e2, input logic [15:0] e3, input string req);
    @(negedge clk); pad_in[p] = v;
    @(posedge clk); @(posedge clk); @(negedge clk); check({16'h0, irq_o}, {16'h0, e1}, req);
    @(posedge clk); @(negedge clk); check({16'h0, irq_o}, {16'h0, e2}, req);
    @(posedge clk); @(negedge clk); check({16'h0, irq_o}, {16'h0, e3}, req);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check({16'h0, irq_o}, 32'h0, "R1 irq after reset");
    rd_check(12'h980, 32'h0, "R1 slot reg0");
    rd_check(12'h98C, 32'h0, "R1 slot reg3");
    rd_check(12'h00C, 32'h0, "R1 cfg pad3");
  endtask

  task automatic t_cfg_rb();
    wr(12'h024, 32'hDEAD_BEEF);
    rd_check(12'h024, 32'hDEAD_BEEF, "R3 cfg pad9 readback");
    wr(12'h024, 32'h0);
    rd_check(12'h024, 32'h0, "R3 cfg pad9 rewrite");
  endtask

  task automatic t_rise();
    wr(12'h004, EN | RISE);
    smap[0] = 8'd1; push_map();
    step(1, 1'b1, 16'h0, 16'h0001, 16'h0, "R5 rising pulse");
    step(1, 1'b0, 16'h0, 16'h0, 16'h0, "R5 falling ignored");
  endtask

  task automatic t_fall();
    wr(12'h008, EN | FALL);
    smap[1] = 8'd2; push_map();
    step(2, 1'b1, 16'h0, 16'h0, 16'h0, "R6 rising ignored");
    step(2, 1'b0, 16'h0, 16'h0002, 16'h0, "R6 falling pulse");
  endtask

  task automatic t_both();
    wr(12'h00C, EN | FALL | RISE);
    smap[2] = 8'd3; push_map();
    step(3, 1'b1, 16'h0, 16'h0004, 16'h0, "R7 rise pulse");
    step(3, 1'b0, 16'h0, 16'h0004, 16'h0, "R7 fall pulse");
  endtask

  task automatic t_level();
    wr(12'h010, EN | LVL | RISE);
    smap[3] = 8'd4; push_map();
    step(4, 1'b1, 16'h0, 16'h0008, 16'h0008, "R8 level high");
    repeat (5) @(negedge clk);
    check({16'h0, irq_o}, 32'h8, "R8 level held");
    step(4, 1'b0, 16'h0008, 16'h0, 16'h0, "R8 level low");
  endtask

  task automatic t_disabled();
    wr(12'h014, LVL | RISE | FALL);
    smap[4] = 8'd5; push_map();
    step(5, 1'b1, 16'h0, 16'h0, 16'h0, "R4 disabled rise");
    step(5, 1'b0, 16'h0, 16'h0, 16'h0, "R4 disabled fall");
  endtask

  task automatic t_layout();
    wr(12'h01C, EN | RISE);
    smap[5] = 8'd7; push_map();
    rd_check(12'h984, {smap[7], smap[6], 8'd7, smap[4]}, "R2 reg1 readback");
    step(7, 1'b1, 16'h0, 16'h0020, 16'h0, "R2 slot5 from reg1 byte1");
    pad_in[7] = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic t_oob_index();
    smap[6] = 8'd33; push_map();
    step(1, 1'b1, 16'h0, 16'h0001, 16'h0, "R9 index 33 not aliased to pad1");
    pad_in[1] = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic t_multi();
    smap[7] = 8'd1; smap[8] = 8'd1; push_map();
    step(1, 1'b1, 16'h0, 16'h0181, 16'h0, "R11 three lines one pad");
    pad_in[1] = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic t_ignore();
    logic [31:0] r0;
    r0 = {smap[3], smap[2], smap[1], smap[0]};
    wr(12'h990, 32'hFFFF_FFFF);
    wr(12'h981, 32'h1111_1111);
    wr(12'h080, 32'hFFFF_FFFF);
    wr(12'h006, 32'hFFFF_FFFF);
    rd_check(12'h980, r0, "R10 slot reg0 unchanged");
    rd_check(12'h990, 32'h0, "R10 read beyond slots");
    rd_check(12'h080, 32'h0, "R10 read beyond cfg");
    rd_check(12'h004, EN | RISE, "R10 cfg pad1 unchanged");
    step(1, 1'b1, 16'h0, 16'h0181, 16'h0, "R10 routing unchanged");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) smap[i] = 8'd31;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    push_map();
    t_cfg_rb();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_disabled();
    t_layout();
    t_oob_index();
    t_multi();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule